// File: doc/BRIEF.md
# Address-Collision Busy Arbiter

This block sits beside a two-port memory and decides, every clock, which port gives way when both ports reach for the same word. A port that loses is told so through an active-low busy flag, and any write it requests in that cycle is blocked through a per-port inhibit output, so the storage array never sees two writers on one location.

A strap input picks one of two roles. In the master role the block makes its own decision from the two ports' enables and addresses and drives the busy flags from it. In the slave role it makes no decision of its own: the busy flags copy a pair of external busy inputs. Several slices of memory can then be placed side by side for a wider word, with one slice in the master role and the others following its decision, so that every slice blocks the same port.

The decision uses history. A port that was already on the contested address in the previous cycle keeps it, and the newcomer is flagged busy. When both ports arrive on the same address in the same cycle, the left port (port A) wins by fixed priority. Busy lasts only as long as the collision does.

Top module: `collision_busy_arb`

## Requirements
- R1: After reset, no port counts as having been active, so the first collision after reset is a same-cycle start, and with no collision both busy flags read 1 and both inhibits read 0.
- R2: In the master role a collision exists only when both enables are 1 and both addresses are equal; otherwise both busy flags are 1 (not busy).
- R3: In the master role, when both ports start on the same address in the same cycle (neither was enabled on that address the cycle before), port B's busy flag is 0 and port A's is 1.
- R4: In the master role, a port that was enabled on an address in the previous cycle and still is keeps access; the other port, newly arriving there, gets busy flag 0.
- R5: In the master role, while a collision persists with both ports unchanged, the port flagged busy stays the same from cycle to cycle.
- R6: Busy flags are combinational on the current inputs: the cycle the collision ends, both flags return to 1.
- R7: A port's write-inhibit output is 1 exactly when that port is enabled, requests a write, and its busy flag reads 0; reads and unflagged ports are never inhibited.
- R8: In the slave role (mode input 0) each busy flag equals the matching external busy input, regardless of addresses; the inhibit follows that flag as in R7.
- R9: The two busy flags are never 0 together in the master role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| master_mode | input | 1 | 1 = master role, 0 = slave role |
| a_en | input | 1 | Port A access enable |
| a_addr | input | ADDR_W | Port A address |
| a_wr | input | 1 | Port A write request |
| b_en | input | 1 | Port B access enable |
| b_addr | input | ADDR_W | Port B address |
| b_wr | input | 1 | Port B write request |
| a_busy_in_n | input | 1 | External busy for port A (slave role), active low |
| b_busy_in_n | input | 1 | External busy for port B (slave role), active low |
| a_busy_n | output | 1 | Port A busy flag, active low |
| b_busy_n | output | 1 | Port B busy flag, active low |
| a_wr_blk | output | 1 | Port A write inhibit |
| b_wr_blk | output | 1 | Port B write inhibit |

## Verification
The two functions that meet in one cycle are the incumbent rule and the same-cycle tie rule: one port may already hold an address while the other port, or both, moves onto it at the very edge where history is updated. The bench provokes this by switching addresses on both ports in the same cycle, by releasing and re-entering an address, and by random traffic over only four addresses, and judges each cycle against a behavioural model that keeps its own record of the previous cycle's enables, addresses and winner.

// File: rtl/collision_busy_arb.sv
module collision_busy_arb #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              a_en,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_wr,
  input  logic              b_en,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_wr,
  input  logic              a_busy_in_n,
  input  logic              b_busy_in_n,
  output logic              a_busy_n,
  output logic              b_busy_n,
  output logic              a_wr_blk,
  output logic              b_wr_blk
);

  logic              a_seen_q, b_seen_q;
  logic [ADDR_W-1:0] a_addr_q, b_addr_q;
  logic              right_owns_q;
  logic              right_wins;

  wire collide = a_en & b_en & (a_addr == b_addr);
  wire a_cont  = a_seen_q & (a_addr_q == a_addr);
  wire b_cont  = b_seen_q & (b_addr_q == b_addr);

  always_comb begin
    case ({a_cont, b_cont})
      2'b10:   right_wins = 1'b0;
      2'b01:   right_wins = 1'b1;
      2'b11:   right_wins = right_owns_q;
      default: right_wins = 1'b0;
    endcase
  end

  wire arb_a_busy = collide & right_wins;
  wire arb_b_busy = collide & ~right_wins;

  assign a_busy_n = master_mode ? ~arb_a_busy : a_busy_in_n;
  assign b_busy_n = master_mode ? ~arb_b_busy : b_busy_in_n;
  assign a_wr_blk = a_en & a_wr & ~a_busy_n;
  assign b_wr_blk = b_en & b_wr & ~b_busy_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_seen_q     <= 1'b0;
      b_seen_q     <= 1'b0;
      a_addr_q     <= '0;
      b_addr_q     <= '0;
      right_owns_q <= 1'b0;
    end else begin
      a_seen_q <= a_en;
      b_seen_q <= b_en;
      a_addr_q <= a_addr;
      b_addr_q <= b_addr;
      if (collide) right_owns_q <= right_wins;
    end
  end

endmodule

module collision_busy_arb_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master_mode,
  input logic              a_en,
  input logic [ADDR_W-1:0] a_addr,
  input logic              a_wr,
  input logic              b_en,
  input logic [ADDR_W-1:0] b_addr,
  input logic              b_wr,
  input logic              a_busy_in_n,
  input logic              b_busy_in_n,
  input logic              a_busy_n,
  input logic              b_busy_n,
  input logic              a_wr_blk,
  input logic              b_wr_blk
);

  wire same = a_en && b_en && (a_addr == b_addr);

  // R2
  idle_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode && !same |-> a_busy_n && b_busy_n);

  // R9
  one_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode |-> a_busy_n || b_busy_n);

  // R4
  incumbent_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode && same && $past(a_en && !b_en) && $past(a_addr) == a_addr
    |-> !b_busy_n && a_busy_n);

  // R4
  incumbent_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode && same && $past(b_en && !a_en) && $past(b_addr) == b_addr
    |-> !a_busy_n && b_busy_n);

  // R5
  hold_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode && same && $past(master_mode && same)
    && $stable(a_addr) && $stable(b_addr)
    |-> $stable(a_busy_n) && $stable(b_busy_n));

  // R8
  slave_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> a_busy_n == a_busy_in_n && b_busy_n == b_busy_in_n);

  // R7
  inhibit_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_wr_blk == (a_en && a_wr && !a_busy_n));

  // R7
  inhibit_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_wr_blk == (b_en && b_wr && !b_busy_n));

endmodule

bind collision_busy_arb collision_busy_arb_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/collision_busy_arb_bench.sv
`timescale 1ns/100ps
module collision_busy_arb_bench;
  localparam int AW = 15;

  logic clk = 0, rst_n = 0, master_mode = 1;
  logic a_en = 0, a_wr = 0, b_en = 0, b_wr = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic a_busy_in_n = 1, b_busy_in_n = 1;
  logic a_busy_n, b_busy_n, a_wr_blk, b_wr_blk;

  int checks = 0, errors = 0;
  bit done = 0;
  int p_aen = 0, p_ben = 0, p_aaddr = 0, p_baddr = 0, owner_r = 0;

  always #2.5 clk = ~clk;

  collision_busy_arb #(.ADDR_W(AW)) u_collision_busy_arb (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: apply inputs, compare against the model, advance the model.
  task automatic cyc(input bit m, input bit ae, input int aa, input bit aw,
                     input bit be, input int ba, input bit bw,
                     input bit ai = 1, input bit bi = 1, input string req = "R2");
    int ea, eb, rw;
    bit coll, ac, bc;
    @(posedge clk); #1;
    master_mode = m; a_en = ae; a_addr = aa[AW-1:0]; a_wr = aw;
    b_en = be; b_addr = ba[AW-1:0]; b_wr = bw; a_busy_in_n = ai; b_busy_in_n = bi;
    #1;
    coll = ae && be && (aa == ba);
    ac = p_aen != 0 && p_aaddr == aa;
    bc = p_ben != 0 && p_baddr == ba;
    if (ac && !bc) rw = 0;
    else if (bc && !ac) rw = 1;
    else if (ac && bc) rw = owner_r;
    else rw = 0;
    if (m) begin
      ea = (coll && rw == 1) ? 0 : 1;
      eb = (coll && rw == 0) ? 0 : 1;
    end else begin
      ea = ai; eb = bi;
    end
    chk({req, " busyA"}, a_busy_n, ea);
    chk({req, " busyB"}, b_busy_n, eb);
    chk("R7 blkA", a_wr_blk, (ae && aw && ea == 0) ? 1 : 0);
    chk("R7 blkB", b_wr_blk, (be && bw && eb == 0) ? 1 : 0);
    if (coll) owner_r = rw;
    p_aen = ae; p_ben = be; p_aaddr = aa; p_baddr = ba;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset busyA", a_busy_n, 1);
    chk("R1 reset busyB", b_busy_n, 1);
    chk("R1 reset blkA", a_wr_blk, 0);
    rst_n = 1;
    // R1/R3: first collision after reset is a tie; A wins
    cyc(1, 1, 5, 1, 1, 5, 1, 1, 1, "R3");
    // R5: persists
    cyc(1, 1, 5, 1, 1, 5, 1, 1, 1, "R5");
    cyc(1, 1, 5, 0, 1, 5, 1, 1, 1, "R5");
    // R6: end collision
    cyc(1, 1, 5, 1, 0, 5, 1, 1, 1, "R6");
    // R4: A incumbent, B arrives
    cyc(1, 1, 5, 1, 1, 5, 1, 1, 1, "R4");
    cyc(1, 0, 0, 0, 0, 0, 0, 1, 1, "R2");
    // R4: B incumbent, A arrives
    cyc(1, 0, 0, 0, 1, 9, 0, 1, 1, "R2");
    cyc(1, 1, 9, 1, 1, 9, 1, 1, 1, "R4");
    cyc(1, 1, 9, 1, 1, 9, 0, 1, 1, "R5");
    // R2: different addresses
    cyc(1, 1, 3, 1, 1, 4, 1, 1, 1, "R2");
    // R3: both switch to a new shared address in one cycle
    cyc(1, 1, 7, 1, 1, 7, 1, 1, 1, "R3");
    // R4: B moves away and back while A stays
    cyc(1, 1, 7, 1, 1, 8, 1, 1, 1, "R2");
    cyc(1, 1, 7, 1, 1, 7, 1, 1, 1, "R4");
    // R8: slave role ignores addresses
    cyc(0, 1, 2, 1, 1, 2, 1, 1, 1, "R8");
    cyc(0, 1, 2, 1, 1, 6, 1, 0, 1, "R8");
    cyc(0, 1, 2, 0, 1, 6, 1, 1, 0, "R8");
    // random traffic over few addresses
    for (int i = 0; i < 3000; i++) begin
      bit m = ($urandom % 8) != 0;
      cyc(m, $urandom % 4 != 0, $urandom % 4, $urandom % 2,
          $urandom % 4 != 0, $urandom % 4, $urandom % 2,
          $urandom % 2, $urandom % 2, m ? "R4" : "R8");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule